// File: doc/BRIEF.md
# Sleep State Request Qualifier

This block turns two asynchronous, active-low sleep request pins into a qualified power state for the rest of the chip. One pin asks for light sleep. The other pin selects whether that sleep should be deep. Each pin first goes through a two-flop synchronizer. It then goes through a counter-based deglitch filter, so noise on long board traces cannot push the chip into or out of sleep.

The sleep depth is not taken straight from the pins. A confirmed falling level on the light-sleep pin starts a fixed delay timer. When that timer expires, the filtered deep-sleep level decides the state: low gives deep sleep, high gives light sleep. A filtered light-sleep pin that goes high again cancels a running timer, and it wakes the block from either sleep state. Every change of the output state is marked by a one-cycle strobe.

All time windows are given in microseconds and scaled by a clock-rate parameter (cycles per microsecond). By default the deglitch window is 2 µs and the sleep delay is 200 µs.

Top module: `sleep_req_qualifier`

## Requirements
- R1: A synchronized pin level that differs from the filtered level is accepted only after it has held for FILT cycles in a row (FILT = CLK_PER_US*FILT_US). A raw change sampled at clock edge 1 reaches the filtered level at edge 2+FILT.
- R2: A pulse on either pin that is shorter than FILT cycles leaves the output state and the strobe unchanged.
- R3: While the state is active, the filtered light-sleep level must stay low for DELAY cycles (DELAY = CLK_PER_US*DELAY_US) before a sleep state is entered. The state changes on the DELAY-th edge after the filtered level falls.
- R4: At timer expiry, if the filtered deep-sleep level is low, the state becomes deep sleep, encoded 2'b10 on pwr_state.
- R5: At timer expiry, if the filtered deep-sleep level is high, the state becomes light sleep, encoded 2'b01 on pwr_state.
- R6: If the filtered light-sleep level returns high before expiry, the timer is cancelled and the state stays active (2'b00). The next request times a full DELAY again.
- R7: In either sleep state, a high filtered light-sleep level returns the state to active on the next edge.
- R8: While in a sleep state, changes on the deep-sleep pin have no effect on the state.
- R9: state_chg is high for exactly the one cycle in which pwr_state takes a new value, and it is low at all other times.
- R10: During and after reset, pwr_state is active and state_chg is low. The synchronizers and filters are preloaded high, so pins held high after reset cause no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| light_req_n | input | 1 | Raw asynchronous light-sleep request, active low |
| deep_req_n | input | 1 | Raw asynchronous deep-sleep select, active low |
| pwr_state | output | 2 | Qualified state: 00 active, 01 light sleep, 10 deep sleep |
| state_chg | output | 1 | One-cycle pulse on each change of pwr_state |

## Verification
A filter counter that is off by one moves the sleep entry edge by one cycle. It also lets a pulse exactly one cycle shorter than the window through, and both are visible at pwr_state within about DELAY+FILT cycles of the stimulus. A timer that does not clear on cancel, or that samples the deep pin at the wrong moment, shows up as the wrong sleep code or as an early entry on the next request. A stuck or missing strobe shows up on the very cycle the state register changes.

// File: rtl/sleep_qual_pkg.sv
package sleep_qual_pkg;

    typedef enum logic [1:0] {
        PST_ACTIVE = 2'b00,
        PST_LIGHT  = 2'b01,
        PST_DEEP   = 2'b10
    } pwr_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_LVL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
    parameter int WINDOW = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic level
);

    localparam int CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d = q;
        if (sync_in == q.lvl) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(WINDOW - 1)) begin
            d.lvl = sync_in;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{lvl: 1'b1, cnt: '0};
        else        q <= d;
    end

    assign level = q.lvl;

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.lvl) |-> (q.lvl == $past(sync_in)));               // R1
    AST_FILT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(WINDOW));                                          // R2

endmodule

// File: rtl/sleep_resolver.sv
module sleep_resolver
    import sleep_qual_pkg::*;
#(
    parameter int DELAY = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       light_f,
    input  logic       deep_f,
    output pwr_state_e state,
    output logic       chg
);

    localparam int TW = $clog2(DELAY + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [TW-1:0] tmr;
        logic          chg;
    } res_t;

    res_t q, d;

    always_comb begin
        d     = q;
        d.chg = 1'b0;
        case (q.st)
            PST_ACTIVE: begin
                if (light_f) begin
                    d.tmr = '0;
                end else if (q.tmr == TW'(DELAY - 1)) begin
                    d.st  = deep_f ? PST_LIGHT : PST_DEEP;
                    d.tmr = '0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            PST_LIGHT, PST_DEEP: begin
                d.tmr = '0;
                if (light_f) d.st = PST_ACTIVE;
            end
            default: begin
                d.st  = PST_ACTIVE;
                d.tmr = '0;
            end
        endcase
        d.chg = (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PST_ACTIVE, tmr: '0, chg: 1'b0};
        else        q <= d;
    end

    assign state = q.st;
    assign chg   = q.chg;

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmr < TW'(DELAY));                                           // R3
    AST_ENTRY_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == PST_ACTIVE && q.st != PST_ACTIVE) |-> !$past(light_f)); // R3
    AST_DEEP_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == PST_ACTIVE && q.st == PST_DEEP) |-> !$past(deep_f));    // R4
    AST_LIGHT_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == PST_ACTIVE && q.st == PST_LIGHT) |-> $past(deep_f));    // R5
    AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != PST_ACTIVE && light_f) |=> (q.st == PST_ACTIVE));     // R7
    AST_NO_SLEEP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) != PST_ACTIVE && q.st != PST_ACTIVE) |-> $stable(q.st)); // R8
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.st) |-> q.chg);                                     // R9
    AST_STROBE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.chg |-> !$stable(q.st));                                     // R9
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        q.st inside {PST_ACTIVE, PST_LIGHT, PST_DEEP});                // R10

endmodule

// File: rtl/sleep_req_qualifier.sv
module sleep_req_qualifier
    import sleep_qual_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int FILT_US    = 2,
    parameter int DELAY_US   = 200,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       light_req_n,
    input  logic       deep_req_n,
    output logic [1:0] pwr_state,
    output logic       state_chg
);

    localparam int FILT_CYC  = CLK_PER_US * FILT_US;
    localparam int DELAY_CYC = CLK_PER_US * DELAY_US;
    localparam int NPIN      = 2;
    localparam int PIN_LIGHT = 0;
    localparam int PIN_DEEP  = 1;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] synced;
    logic [NPIN-1:0] filtered;
    pwr_state_e      st;

    assign raw[PIN_LIGHT] = light_req_n;
    assign raw[PIN_DEEP]  = deep_req_n;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pin_sync #(
            .STAGES    (SYNC_STG),
            .RESET_LVL (1'b1)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw[i]),
            .sync_out (synced[i])
        );

        glitch_filter #(
            .WINDOW (FILT_CYC)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (synced[i]),
            .level   (filtered[i])
        );
    end

    sleep_resolver #(
        .DELAY (DELAY_CYC)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .light_f (filtered[PIN_LIGHT]),
        .deep_f  (filtered[PIN_DEEP]),
        .state   (st),
        .chg     (state_chg)
    );

    assign pwr_state = st;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pwr_state == 2'b00 || rst_n));                     // R10

endmodule

// File: tb/sleep_req_qualifier_test.sv
`timescale 1ns/1ps
module sleep_req_qualifier_test;

    localparam int CPU  = 2;
    localparam int FUS  = 2;
    localparam int DUS  = 10;
    localparam int F    = CPU * FUS;   // 4
    localparam int D    = CPU * DUS;   // 20
    localparam int LAT  = 2 + F;       // raw-to-filtered edges

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       light_n = 1'b1;
    logic       deep_n = 1'b1;
    logic [1:0] pwr_state;
    logic       state_chg;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    logic [1:0] seen = 2'b00;
    bit done = 0;

    always #4 clk = ~clk;

    sleep_req_qualifier #(
        .CLK_PER_US (CPU),
        .FILT_US    (FUS),
        .DELAY_US   (DUS),
        .SYNC_STG   (2)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .light_req_n (light_n),
        .deep_req_n  (deep_n),
        .pwr_state   (pwr_state),
        .state_chg   (state_chg)
    );

    always @(negedge clk) begin
        if (rst_n && state_chg) strobes++;
        if (rst_n && pwr_state != 2'b00) seen = pwr_state;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // light low for L raw cycles with deep level dv held long before
    task automatic light_window(input int L, input logic dv, input string req);
        int s0;
        @(negedge clk); deep_n = dv;
        repeat (LAT + 2) @(negedge clk);
        s0 = strobes; seen = 2'b00;
        light_n = 1'b0;
        repeat (L) @(negedge clk);
        light_n = 1'b1;
        repeat (LAT + 4) @(negedge clk);
        deep_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        if (L >= D) begin
            chk(req, seen, dv ? 1 : 2);
            chk({req, " strobes"}, strobes - s0, 2);
        end else begin
            chk(req, seen, 0);
            chk({req, " strobes"}, strobes - s0, 0);
        end
        chk({req, " final active"}, pwr_state, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report;
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        chk("R10 state in reset", pwr_state, 0);
        chk("R10 strobe in reset", state_chg, 0);
        rst_n = 1'b1;
        repeat (LAT + 10) @(negedge clk);
        chk("R10 no transition after reset", strobes, 0);
        chk("R10 active after reset", pwr_state, 0);

        // R2: short light pulses rejected
        for (int p = 1; p < F; p++) begin
            s0 = strobes;
            light_n = 1'b0;
            repeat (p) @(negedge clk);
            light_n = 1'b1;
            repeat (LAT + D + 4) @(negedge clk);
            chk("R2 light glitch", strobes - s0, 0);
        end

        // R3/R4/R5/R6 sweep of low duration and deep level
        for (int dv = 0; dv < 2; dv++) begin
            for (int L = D - 3; L <= D + 2; L++) begin
                light_window(L, dv[0], L >= D ? (dv ? "R5" : "R4") : "R6");
            end
        end
        // R6: a cancelled run then a full run still needs full delay
        light_window(D - 1, 1'b1, "R6 cancel");
        light_window(D, 1'b1, "R6 restart full");

        // R1/R3 exact entry edge, deep selected
        @(negedge clk); deep_n = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        light_n = 1'b0;
        edges(LAT + D - 1);
        chk("R1 R3 still active before expiry", pwr_state, 0);
        edges(1);
        chk("R4 deep at expiry edge", pwr_state, 2);
        chk("R9 strobe on entry", state_chg, 1);
        edges(1);
        chk("R9 strobe one cycle", state_chg, 0);

        // R8: deep pin changes while asleep ignored
        @(negedge clk); deep_n = 1'b1;
        s0 = strobes;
        repeat (LAT + 3 * F) @(negedge clk);
        chk("R8 deep release ignored", pwr_state, 2);
        chk("R8 no strobe", strobes - s0, 0);

        // R7: wake latency
        @(negedge clk); light_n = 1'b1;
        edges(LAT);
        chk("R7 still asleep until filtered", pwr_state, 2);
        edges(1);
        chk("R7 active next edge", pwr_state, 0);
        chk("R9 strobe on wake", state_chg, 1);
        repeat (LAT + 2) @(negedge clk);

        // R2: deep glitch around expiry does not select deep
        s0 = strobes;
        light_n = 1'b0;
        repeat (D - 1) @(negedge clk);
        deep_n = 1'b0;
        repeat (F - 1) @(negedge clk);
        deep_n = 1'b1;
        repeat (LAT + 4) @(negedge clk);
        chk("R2 deep glitch -> light", pwr_state, 1);
        // R8 in light: long deep low ignored
        deep_n = 1'b0;
        repeat (LAT + 3 * F) @(negedge clk);
        chk("R8 light held despite deep", pwr_state, 1);
        light_n = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        deep_n = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        chk("R7 wake from light", pwr_state, 0);
        chk("R9 two strobes", strobes - s0, 2);

        report;
        done = 1;
        $finish;
    end

endmodule